// File: doc/BRIEF.md
# Variable-Width Register Stack

This block is the general-purpose register file of a stack-oriented processor. Each of its entries holds one data item between 0 and 255 bits wide. Each entry also has a length tag that records how many of its low bits carry real data. An item always sits at bit 0 of its entry and fills upward. Bits above the length are stored as zero. An entry never holds more than one item, however short the item is.

The host pushes and pops whole items, or replaces the top item in a single cycle. It can also read or write one bit of any live entry. A bit access names the entry by its depth below the top (depth 0 is the top) and names the bit by its index. Every result, length report and fault flag is registered and appears one clock after the request.

A small number of entries is held in reserve. An ordinary push that would eat into the reserve is refused with an overflow fault. A push marked as privileged may still use the reserve, so a fault report can always be pushed. Popping an empty stack raises an underflow fault. A bit index at or beyond the entry's length, or a depth beyond the live entries, raises a range fault. A faulting request changes nothing.

Top module: `vwstack`

## Requirements
- R1: After synchronous reset, `count` is 0 and all of `pop_valid`, `rd_valid`, `err_overflow`, `err_underflow` and `err_range` are low.
- R2: A push stores `push_data` with bits at and above `push_len` forced to zero, records `push_len` as the entry's length, and raises `count` by one. A pop returns the top item on `pop_data`/`pop_len` with `pop_valid` high one cycle later, in last-in-first-out order, and lowers `count` by one.
- R3: An ordinary push (`push_priv` low) while `count` >= DEPTH-RESERVE (62 by default) raises `err_overflow` for one cycle and leaves `count` and the contents unchanged.
- R4: A privileged push (`push_priv` high) succeeds while `count` < DEPTH (64), so it can fill the reserve. At `count` = DEPTH it raises `err_overflow` and changes nothing.
- R5: A pop, or a push and pop together, on an empty stack raises `err_underflow`, keeps `pop_valid` low and leaves `count` at 0.
- R6: Push and pop asserted together on a non-empty stack return the old top item through the pop outputs, write the new item in its place, and leave `count` unchanged.
- R7: A bit read (`acc_rd`) at depth d returns bit `acc_bit` of the entry d places below the top on `rd_bit`, that entry's length on `rd_len`, and `rd_valid` high, one cycle later.
- R8: A bit write (`acc_wr`) sets bit `acc_bit` of the addressed entry to `acc_wdata` and leaves every other bit and the length unchanged. It does not raise `rd_valid`.
- R9: A bit access with `acc_bit` >= the entry's length, or with `acc_depth` >= `count`, raises `err_range` for one cycle, keeps `rd_valid` low and writes nothing.
- R10: A zero-length item takes one entry on push and returns length 0 and all-zero data on pop. Any bit access to it raises `err_range`.
- R11: A bit access requested in the same cycle as a push or pop is dropped: no `rd_valid`, no write and no `err_range`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Push request |
| push_priv | input | 1 | Push may use the reserved entries |
| push_len | input | 8 | Valid bit count of the pushed item |
| push_data | input | 255 | Pushed item, bit 0 first |
| pop | input | 1 | Pop request |
| acc_rd | input | 1 | Bit read request |
| acc_wr | input | 1 | Bit write request |
| acc_depth | input | 6 | Entry addressed by a bit access, 0 = top |
| acc_bit | input | 8 | Bit index addressed by a bit access |
| acc_wdata | input | 1 | Value for a bit write |
| pop_valid | output | 1 | Popped item is on pop_data/pop_len |
| pop_len | output | 8 | Length of the popped item |
| pop_data | output | 255 | Popped item |
| rd_valid | output | 1 | Bit read result is valid |
| rd_bit | output | 1 | Bit read value |
| rd_len | output | 8 | Length of the entry that was read |
| err_overflow | output | 1 | Push refused, stack full up to its limit |
| err_underflow | output | 1 | Pop refused, stack empty |
| err_range | output | 1 | Bit access outside the live entries or bits |
| count | output | 7 | Number of live entries |

## Verification
The bench fills the stack to the ordinary limit and then into the reserve, and probes both boundaries. A design that counted the reserve wrongly would refuse the 62nd push or accept a 65th. It pushes zero-length and full 255-bit items and pops them back. This catches a mask that leaks stale high bits or an off-by-one at bit 254. Bit accesses land exactly on the length boundary and one entry beyond the live stack. An unguarded write would then show up as a changed bit in the later popped word. Replace, and bit requests raised together with a push or pop, expose any design that moves the pointer on a replace or lets a dropped access write.

// File: rtl/vws_pkg.sv
package vws_pkg;

  // Action chosen for the current cycle by the controller.
  typedef enum logic [2:0] {
    ACT_NONE = 3'd0,
    ACT_PUSH = 3'd1,
    ACT_POP  = 3'd2,
    ACT_REPL = 3'd3,
    ACT_BIT  = 3'd4
  } vws_act_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic rng;
  } vws_err_t;

endpackage

// File: rtl/vws_ctrl.sv
module vws_ctrl #(
  parameter int DEPTH   = 64,
  parameter int RESERVE = 2,
  parameter int LEN_W   = 8,
  parameter int AW      = 6,
  parameter int CW      = 7
) (
  input  logic                 push_i,
  input  logic                 priv_i,
  input  logic                 pop_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [AW-1:0]        depth_i,
  input  logic [LEN_W-1:0]     bit_i,
  input  logic [CW-1:0]        count_i,
  input  logic [LEN_W-1:0]     tgt_len_i,
  output vws_pkg::vws_act_e    act_o,
  output vws_pkg::vws_err_t    err_o,
  output logic [CW-1:0]        count_nxt_o,
  output logic [AW-1:0]        top_row_o,
  output logic [AW-1:0]        new_row_o,
  output logic [AW-1:0]        tgt_row_o
);
  import vws_pkg::*;

  localparam logic [CW-1:0] FULL_LIM = CW'(DEPTH);
  localparam logic [CW-1:0] NORM_LIM = CW'(DEPTH - RESERVE);

  logic [CW-1:0] limit;
  logic          empty;
  logic          depth_bad;
  logic          bit_bad;

  assign limit     = priv_i ? FULL_LIM : NORM_LIM;
  assign empty     = (count_i == '0);
  assign depth_bad = (CW'(depth_i) >= count_i);
  assign bit_bad   = (bit_i >= tgt_len_i);

  // Row indices wrap in AW bits; only meaningful when the stack state allows.
  assign top_row_o = AW'(count_i) - AW'(1);
  assign new_row_o = AW'(count_i);
  assign tgt_row_o = AW'(count_i) - AW'(1) - depth_i;

  always_comb begin
    act_o       = ACT_NONE;
    err_o       = '0;
    count_nxt_o = count_i;
    if (push_i && pop_i) begin
      if (empty) err_o.unf = 1'b1;
      else       act_o     = ACT_REPL;
    end else if (push_i) begin
      if (count_i >= limit) begin
        err_o.ovf = 1'b1;
      end else begin
        act_o       = ACT_PUSH;
        count_nxt_o = count_i + CW'(1);
      end
    end else if (pop_i) begin
      if (empty) begin
        err_o.unf = 1'b1;
      end else begin
        act_o       = ACT_POP;
        count_nxt_o = count_i - CW'(1);
      end
    end else if (rd_i || wr_i) begin
      if (depth_bad || bit_bad) err_o.rng = 1'b1;
      else                      act_o     = ACT_BIT;
    end
  end

endmodule

// File: rtl/vws_store.sv
module vws_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 255,
  parameter int LEN_W = 8,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             row_we,
  input  logic [AW-1:0]    row_idx,
  input  logic [WIDTH-1:0] row_data,
  input  logic [LEN_W-1:0] row_len,
  input  logic             bit_we,
  input  logic [AW-1:0]    bit_row,
  input  logic [LEN_W-1:0] bit_idx,
  input  logic             bit_val,
  input  logic [AW-1:0]    top_row,
  output logic [WIDTH-1:0] top_data,
  output logic [LEN_W-1:0] top_len,
  output logic             tgt_bit,
  output logic [LEN_W-1:0] tgt_len
);

  logic [WIDTH-1:0] data_mem [DEPTH];
  logic [LEN_W-1:0] len_mem  [DEPTH];
  logic [WIDTH-1:0] masked;
  logic [WIDTH-1:0] tgt_word;

  // Clear every bit at or above the item length before it is stored.
  for (genvar b = 0; b < WIDTH; b++) begin : g_mask
    assign masked[b] = row_data[b] & (LEN_W'(b) < row_len);
  end

  always_ff @(posedge clk) begin
    if (row_we) begin
      data_mem[row_idx] <= masked;
      len_mem[row_idx]  <= row_len;
    end
    if (bit_we) begin
      data_mem[bit_row][bit_idx] <= bit_val;
    end
  end

  assign top_data = data_mem[top_row];
  assign top_len  = len_mem[top_row];
  assign tgt_word = data_mem[bit_row];
  assign tgt_bit  = tgt_word[bit_idx];
  assign tgt_len  = len_mem[bit_row];

endmodule

// File: rtl/vwstack.sv
module vwstack #(
  parameter int DEPTH   = 64,
  parameter int WIDTH   = 255,
  parameter int RESERVE = 2,
  localparam int LEN_W  = $clog2(WIDTH + 1),
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             push_priv,
  input  logic [LEN_W-1:0] push_len,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  logic [AW-1:0]    acc_depth,
  input  logic [LEN_W-1:0] acc_bit,
  input  logic             acc_wdata,
  output logic             pop_valid,
  output logic [LEN_W-1:0] pop_len,
  output logic [WIDTH-1:0] pop_data,
  output logic             rd_valid,
  output logic             rd_bit,
  output logic [LEN_W-1:0] rd_len,
  output logic             err_overflow,
  output logic             err_underflow,
  output logic             err_range,
  output logic [CW-1:0]    count
);
  import vws_pkg::*;

  vws_act_e         act;
  vws_err_t         err;
  logic [CW-1:0]    count_nxt;
  logic [AW-1:0]    top_row;
  logic [AW-1:0]    new_row;
  logic [AW-1:0]    tgt_row;
  logic [WIDTH-1:0] top_data;
  logic [LEN_W-1:0] top_len;
  logic             tgt_bit;
  logic [LEN_W-1:0] tgt_len;
  logic             row_we;
  logic [AW-1:0]    row_idx;
  logic             bit_we;

  vws_ctrl #(
    .DEPTH(DEPTH), .RESERVE(RESERVE), .LEN_W(LEN_W), .AW(AW), .CW(CW)
  ) u_ctrl (
    .push_i      (push),
    .priv_i      (push_priv),
    .pop_i       (pop),
    .rd_i        (acc_rd),
    .wr_i        (acc_wr),
    .depth_i     (acc_depth),
    .bit_i       (acc_bit),
    .count_i     (count),
    .tgt_len_i   (tgt_len),
    .act_o       (act),
    .err_o       (err),
    .count_nxt_o (count_nxt),
    .top_row_o   (top_row),
    .new_row_o   (new_row),
    .tgt_row_o   (tgt_row)
  );

  assign row_we  = (act == ACT_PUSH) || (act == ACT_REPL);
  assign row_idx = (act == ACT_PUSH) ? new_row : top_row;
  assign bit_we  = (act == ACT_BIT) && acc_wr;

  vws_store #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .LEN_W(LEN_W), .AW(AW)
  ) u_store (
    .clk      (clk),
    .row_we   (row_we),
    .row_idx  (row_idx),
    .row_data (push_data),
    .row_len  (push_len),
    .bit_we   (bit_we),
    .bit_row  (tgt_row),
    .bit_idx  (acc_bit),
    .bit_val  (acc_wdata),
    .top_row  (top_row),
    .top_data (top_data),
    .top_len  (top_len),
    .tgt_bit  (tgt_bit),
    .tgt_len  (tgt_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count         <= '0;
      pop_valid     <= 1'b0;
      pop_len       <= '0;
      pop_data      <= '0;
      rd_valid      <= 1'b0;
      rd_bit        <= 1'b0;
      rd_len        <= '0;
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
      err_range     <= 1'b0;
    end else begin
      count         <= count_nxt;
      err_overflow  <= err.ovf;
      err_underflow <= err.unf;
      err_range     <= err.rng;
      pop_valid     <= (act == ACT_POP) || (act == ACT_REPL);
      if ((act == ACT_POP) || (act == ACT_REPL)) begin
        pop_len  <= top_len;
        pop_data <= top_data;
      end
      rd_valid <= (act == ACT_BIT) && acc_rd;
      if ((act == ACT_BIT) && acc_rd) begin
        rd_bit <= tgt_bit;
        rd_len <= tgt_len;
      end
    end
  end

endmodule

// File: rtl/vwstack_chk.sv
module vwstack_chk #(
  parameter int DEPTH   = 64,
  parameter int RESERVE = 2,
  parameter int LEN_W   = 8,
  parameter int CW      = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [CW-1:0]    count,
  input logic             err_overflow,
  input logic             err_underflow,
  input logic             err_range,
  input logic             pop_valid,
  input logic             rd_valid,
  input logic [LEN_W-1:0] rd_len
);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    err_overflow |-> ($stable(count) && (count >= CW'(DEPTH - RESERVE))));

  assert_underflow_empty_R5: assert property (@(posedge clk) disable iff (rst)
    err_underflow |-> ((count == '0) && !pop_valid));

  assert_pop_step_R2: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> ((count == $past(count)) || (count + CW'(1) == $past(count))));

  assert_read_len_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ((rd_len != '0) && !err_range));

  assert_one_fault_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_overflow, err_underflow, err_range}));

  assert_drop_access_R11: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> !rd_valid);

endmodule

bind vwstack vwstack_chk #(
  .DEPTH(DEPTH), .RESERVE(RESERVE), .LEN_W(LEN_W), .CW(CW)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .count         (count),
  .err_overflow  (err_overflow),
  .err_underflow (err_underflow),
  .err_range     (err_range),
  .pop_valid     (pop_valid),
  .rd_valid      (rd_valid),
  .rd_len        (rd_len)
);

// File: tb/vwstack_bench.sv
module vwstack_bench;
  localparam int W = 255;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         push = 1'b0, push_priv = 1'b0, pop = 1'b0;
  logic         acc_rd = 1'b0, acc_wr = 1'b0, acc_wdata = 1'b0;
  logic [7:0]   push_len = '0, acc_bit = '0;
  logic [5:0]   acc_depth = '0;
  logic [W-1:0] push_data = '0;
  logic         pop_valid, rd_valid, rd_bit;
  logic         err_overflow, err_underflow, err_range;
  logic [7:0]   pop_len, rd_len;
  logic [W-1:0] pop_data;
  logic [6:0]   count;
  int           total = 0;
  int           bad = 0;

  always #10 clk = ~clk;

  vwstack u_vwstack (
    .clk(clk), .rst(rst), .push(push), .push_priv(push_priv),
    .push_len(push_len), .push_data(push_data), .pop(pop),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_depth(acc_depth),
    .acc_bit(acc_bit), .acc_wdata(acc_wdata), .pop_valid(pop_valid),
    .pop_len(pop_len), .pop_data(pop_data), .rd_valid(rd_valid),
    .rd_bit(rd_bit), .rd_len(rd_len), .err_overflow(err_overflow),
    .err_underflow(err_underflow), .err_range(err_range), .count(count)
  );

  function automatic logic [W-1:0] pat(input int i);
    logic [W-1:0] r;
    for (int b = 0; b < W; b++) r[b] = ((b * 5 + i * 3) % 7) < 3;
    return r;
  endfunction

  function automatic logic [W-1:0] msk(input logic [W-1:0] d, input int len);
    logic [W-1:0] r;
    for (int b = 0; b < W; b++) r[b] = (b < len) ? d[b] : 1'b0;
    return r;
  endfunction

  function automatic int len_of(input int i);
    return (i == 5) ? 255 : ((i * 41 + 3) % 256);
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    push = 0; push_priv = 0; pop = 0; acc_rd = 0; acc_wr = 0; acc_wdata = 0;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_push(input int len, input logic [W-1:0] d, input logic priv);
    push = 1; push_priv = priv; push_len = 8'(len); push_data = d;
    cycle();
  endtask

  task automatic do_pop();
    pop = 1;
    cycle();
  endtask

  task automatic do_acc(input logic rd, input logic wr, input int depth,
                        input int bitn, input logic val);
    acc_rd = rd; acc_wr = wr; acc_depth = 6'(depth); acc_bit = 8'(bitn);
    acc_wdata = val;
    cycle();
  endtask

  task automatic t_reset();
    chk("R1 count", W'(count), '0);
    chk("R1 pop_valid", W'(pop_valid), '0);
    chk("R1 rd_valid", W'(rd_valid), '0);
    chk("R1 errors", W'({err_overflow, err_underflow, err_range}), '0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 62; i++) begin
      do_push(len_of(i), pat(i), 1'b0);
      chk("R2 push count", W'(count), W'(i + 1));
      chk("R2 push no fault", W'(err_overflow), '0);
    end
    do_push(7, pat(99), 1'b0);
    chk("R3 overflow flag", W'(err_overflow), 1);
    chk("R3 count held", W'(count), 62);
    for (int i = 62; i < 64; i++) begin
      do_push(len_of(i), pat(i), 1'b1);
      chk("R4 reserve push", W'({err_overflow, count}), W'(i + 1));
    end
    do_push(3, pat(98), 1'b1);
    chk("R4 full overflow", W'(err_overflow), 1);
    chk("R4 count at depth", W'(count), 64);
    for (int i = 63; i >= 0; i--) begin
      do_pop();
      chk("R2 pop valid", W'(pop_valid), 1);
      chk("R2 pop len", W'(pop_len), W'(len_of(i)));
      chk("R2 pop data", pop_data, msk(pat(i), len_of(i)));
      chk("R2 pop count", W'(count), W'(i));
    end
  endtask

  task automatic t_underflow();
    do_pop();
    chk("R5 underflow pop", W'({err_underflow, pop_valid}), W'(2'b10));
    chk("R5 count", W'(count), '0);
    push = 1; push_len = 8'd5; push_data = pat(7); pop = 1;
    cycle();
    chk("R5 underflow replace", W'({err_underflow, pop_valid}), W'(2'b10));
    chk("R5 count after replace", W'(count), '0);
  endtask

  task automatic t_replace();
    do_push(20, pat(1), 1'b0);
    do_push(30, pat(2), 1'b0);
    push = 1; push_len = 8'd9; push_data = pat(3); pop = 1;
    cycle();
    chk("R6 replace pop valid", W'(pop_valid), 1);
    chk("R6 replace old len", W'(pop_len), 30);
    chk("R6 replace old data", pop_data, msk(pat(2), 30));
    chk("R6 replace count", W'(count), 2);
    do_pop();
    chk("R6 new top", {pop_data[W-9:0], pop_len}, {msk(pat(3), 9), 8'd9});
    do_pop();
    chk("R6 bottom kept", {pop_data[W-9:0], pop_len}, {msk(pat(1), 20), 8'd20});
  endtask

  task automatic t_bitrw();
    logic [W-1:0] x, y;
    x = msk(pat(100), 40);
    y = msk(pat(101), 12);
    do_push(40, pat(100), 1'b0);
    do_push(12, pat(101), 1'b0);
    do_acc(1, 0, 0, 11, 0);
    chk("R7 read top", W'({rd_valid, rd_bit, rd_len}), W'({1'b1, y[11], 8'd12}));
    do_acc(1, 0, 1, 39, 0);
    chk("R7 read depth1", W'({rd_valid, rd_bit, rd_len}), W'({1'b1, x[39], 8'd40}));
    do_acc(0, 1, 1, 7, ~x[7]);
    chk("R8 write no rd_valid", W'({rd_valid, err_range}), '0);
    do_acc(1, 0, 1, 7, 0);
    chk("R8 read back", W'({rd_valid, rd_bit}), W'({1'b1, ~x[7]}));
    do_pop();
    chk("R8 top untouched", pop_data, y);
    x[7] = ~x[7];
    do_pop();
    chk("R8 written entry", pop_data, x);
    chk("R8 length kept", W'(pop_len), 40);
  endtask

  task automatic t_range();
    do_push(16, pat(50), 1'b0);
    do_acc(1, 0, 0, 16, 0);
    chk("R9 bit at len", W'({err_range, rd_valid}), W'(2'b10));
    do_acc(0, 1, 0, 16, 1);
    chk("R9 write at len", W'(err_range), 1);
    do_acc(1, 0, 1, 0, 0);
    chk("R9 depth beyond", W'({err_range, rd_valid}), W'(2'b10));
    do_acc(0, 1, 3, 2, ~pat(50)[2]);
    chk("R9 write depth beyond", W'(err_range), 1);
    do_acc(1, 0, 0, 15, 0);
    chk("R9 last bit ok", W'({err_range, rd_valid, rd_bit}), W'({2'b01, pat(50)[15]}));
    do_pop();
    chk("R9 no write landed", pop_data, msk(pat(50), 16));
  endtask

  task automatic t_zero();
    do_push(0, '1, 1'b0);
    chk("R10 zero push count", W'(count), 1);
    do_acc(1, 0, 0, 0, 0);
    chk("R10 zero read range", W'({err_range, rd_valid}), W'(2'b10));
    do_pop();
    chk("R10 zero pop", W'({pop_valid, pop_len}), W'(9'h100));
    chk("R10 zero data", pop_data, '0);
    chk("R10 zero count", W'(count), '0);
  endtask

  task automatic t_drop();
    logic [W-1:0] a;
    a = msk(pat(60), 8);
    do_push(8, pat(60), 1'b0);
    do_push(8, pat(61), 1'b0);
    pop = 1; acc_rd = 1; acc_depth = 6'd0; acc_bit = 8'd0;
    cycle();
    chk("R11 pop wins over read", W'({pop_valid, rd_valid, err_range}), W'(3'b100));
    push = 1; push_len = 8'd4; push_data = pat(62);
    acc_wr = 1; acc_depth = 6'd0; acc_bit = 8'd0; acc_wdata = ~a[0];
    cycle();
    chk("R11 push wins over write", W'({err_range, count}), W'(2));
    do_acc(0, 0, 5, 200, 0);
    chk("R11 idle no range", W'(err_range), 0);
    do_pop();
    do_pop();
    chk("R11 dropped write absent", pop_data, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_underflow();
    t_replace();
    t_bitrw();
    t_range();
    t_zero();
    t_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule